// File: doc/BRIEF.md
# Boot Vector Region Remapper

This block overlays a programmable memory window onto address zero, so that a processor coming out of reset fetches its vector table and first instructions from a region chosen by software rather than from whatever sits at the bottom of the map. Software programs a pending start address and a pending window length into staging registers. The translation itself is driven by a second pair of live registers, which take the staged values only when the processor core is held in reset or when software writes a self-clearing load bit.

The staging registers survive a core reset and are cleared only by the full chip reset. This lets firmware stage a new boot image location, reset just the core, and have the core restart from the new region. The live start address comes out of chip reset pointing at the boot ROM. The translation path is purely combinational. An address that lies inside the window has the live start address added to it. Every other address passes through unchanged.

Top module: `boot_remap`

## Requirements
- R1: After chip reset (`chip_rst_n` low), both the staging and live start addresses equal `BOOT_BASE`, both lengths equal `RESET_LEN`, and the load bit (control register bit 0) reads 0. A later chip reset restores the staging registers to these values.
- R2: A write to register index 0 sets the full 32-bit staging start address. A write to index 1 sets the staging length from data bits 7:0, and bits 31:8 of index 1 read as 0.
- R3: Writes to the staging registers leave the live start address, the live length and the translated address unchanged until a load or a core reset occurs.
- R4: Writing the control register (index 3) with bit 0 set makes bit 0 read 1 in the following cycle. In the cycle after that, the live registers hold the staged values and bit 0 reads 0 without further action. Writing bit 0 as 0 has no effect.
- R5: While `core_rst_n` is low, the live registers are copied from the staging registers on every clock edge. The staging registers are not changed by a core reset.
- R6: Writes to the live start address (index 2) and to bits 31:24 of the control register are ignored.
- R7: The live start address reads at index 2, and the live length reads in bits 31:24 of the control register.
- R8: When the live length is 0, the translated address equals the bus address for every address.
- R9: When the live length N is nonzero, the window spans (N+1)*512 bytes. An address below that span is translated to the live start address plus the address, modulo 2^32. An address at or above the span passes unchanged.
- R10: With length 255, the window spans exactly 128 KB: address 0x1FFFF is translated and address 0x20000 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| chip_rst_n | input | 1 | Full chip reset, asynchronous, active low |
| core_rst_n | input | 1 | Processor core reset, active low, sampled on the clock |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_idx | input | 2 | Register index: 0 staging start, 1 staging length, 2 live start, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the indexed register |
| cpu_addr | input | 32 | Bus address from the processor |
| mem_addr | output | 32 | Translated address |

## Verification
The bench uses the default parameter values: a 32-bit address, an 8-bit length and 512-byte units, with a boot ROM base of 0xFFFF0000 and a reset length of 63. At this geometry the largest 128 KB window and its exact edge at 0x20000 can be reached, and so can the wrap of the start-plus-offset sum past 2^32 when the start address is near the top of the map. The reset length puts a live window in place right after chip reset. This means the bench can observe that staging writes leave the live window alone.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  typedef enum logic [1:0] {
    IDX_STG_BASE  = 2'd0,
    IDX_STG_LEN   = 2'd1,
    IDX_LIVE_BASE = 2'd2,
    IDX_CTRL      = 2'd3
  } remap_idx_e;

  localparam int LOAD_BIT = 0;

endpackage

// File: rtl/boot_remap_stage.sv
module boot_remap_stage
  import boot_remap_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              LEN_W     = 8,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFFF_0000,
  parameter logic [LEN_W-1:0]  RESET_LEN = 8'd63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        idx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] stg_base_o,
  output logic [LEN_W-1:0]  stg_len_o,
  output logic              load_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  len_q,  len_d;
  logic              load_q, load_d;
  logic              base_en, len_en, load_set;

  always_comb begin
    base_en  = wr_en_i && (remap_idx_e'(idx_i) == IDX_STG_BASE);
    len_en   = wr_en_i && (remap_idx_e'(idx_i) == IDX_STG_LEN);
    load_set = wr_en_i && (remap_idx_e'(idx_i) == IDX_CTRL) && wdata_i[LOAD_BIT];
    base_d   = base_en ? wdata_i : base_q;
    len_d    = len_en ? wdata_i[LEN_W-1:0] : len_q;
    load_d   = load_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BOOT_BASE;
      len_q  <= RESET_LEN;
      load_q <= 1'b0;
    end else begin
      base_q <= base_d;
      len_q  <= len_d;
      load_q <= load_d;
    end
  end

  assign stg_base_o = base_q;
  assign stg_len_o  = len_q;
  assign load_o     = load_q;

  AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && !load_set) |=> !load_q); // R4

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(base_q) && $stable(len_q))); // R5

endmodule

// File: rtl/boot_remap_live.sv
module boot_remap_live #(
  parameter int                ADDR_W    = 32,
  parameter int                LEN_W     = 8,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFFF_0000,
  parameter logic [LEN_W-1:0]  RESET_LEN = 8'd63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy_i,
  input  logic [ADDR_W-1:0] stg_base_i,
  input  logic [LEN_W-1:0]  stg_len_i,
  output logic [ADDR_W-1:0] live_base_o,
  output logic [LEN_W-1:0]  live_len_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  len_q,  len_d;

  always_comb begin
    base_d = copy_i ? stg_base_i : base_q;
    len_d  = copy_i ? stg_len_i  : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BOOT_BASE;
      len_q  <= RESET_LEN;
    end else begin
      base_q <= base_d;
      len_q  <= len_d;
    end
  end

  assign live_base_o = base_q;
  assign live_len_o  = len_q;

  AST_LIVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_i |=> (base_q == $past(stg_base_i) && len_q == $past(stg_len_i))); // R4

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_i |=> ($stable(base_q) && $stable(len_q))); // R3

endmodule

// File: rtl/boot_remap_xlat.sv
module boot_remap_xlat #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int UNIT_SHIFT = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] live_base_i,
  input  logic [LEN_W-1:0]  live_len_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int SPAN_W = LEN_W + UNIT_SHIFT;

  logic upper_zero;
  logic in_span;
  logic hit;

  generate
    if (SPAN_W < ADDR_W) begin : g_upper
      assign upper_zero = (addr_i[ADDR_W-1:SPAN_W] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    in_span = (addr_i[SPAN_W-1:UNIT_SHIFT] <= live_len_i);
    hit     = (live_len_i != '0) && upper_zero && in_span;
    addr_o  = hit ? (live_base_i + addr_i) : addr_i;
  end

  always_comb begin
    if (hit) begin
      AST_HIT_IN_WINDOW: assert ((addr_i >> SPAN_W) == '0); // R10
    end
  end

endmodule

// File: rtl/boot_remap.sv
module boot_remap
  import boot_remap_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                LEN_W      = 8,
  parameter int                UNIT_SHIFT = 9,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hFFFF_0000,
  parameter logic [LEN_W-1:0]  RESET_LEN  = 8'd63
) (
  input  logic              clk,
  input  logic              chip_rst_n,
  input  logic              core_rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [1:0]        reg_idx,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam int PAD_W = ADDR_W - LEN_W;

  logic              wr_en;
  logic              copy;
  logic              load_q;
  logic [ADDR_W-1:0] stg_base, live_base;
  logic [LEN_W-1:0]  stg_len,  live_len;

  assign wr_en = reg_sel && reg_wr;
  assign copy  = !core_rst_n || load_q;

  boot_remap_stage #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BOOT_BASE(BOOT_BASE), .RESET_LEN(RESET_LEN)
  ) u_stage (
    .clk        (clk),
    .rst_n      (chip_rst_n),
    .wr_en_i    (wr_en),
    .idx_i      (reg_idx),
    .wdata_i    (reg_wdata),
    .stg_base_o (stg_base),
    .stg_len_o  (stg_len),
    .load_o     (load_q)
  );

  boot_remap_live #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BOOT_BASE(BOOT_BASE), .RESET_LEN(RESET_LEN)
  ) u_live (
    .clk         (clk),
    .rst_n       (chip_rst_n),
    .copy_i      (copy),
    .stg_base_i  (stg_base),
    .stg_len_i   (stg_len),
    .live_base_o (live_base),
    .live_len_o  (live_len)
  );

  boot_remap_xlat #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .UNIT_SHIFT(UNIT_SHIFT)
  ) u_xlat (
    .addr_i      (cpu_addr),
    .live_base_i (live_base),
    .live_len_i  (live_len),
    .addr_o      (mem_addr)
  );

  always_comb begin
    unique case (remap_idx_e'(reg_idx))
      IDX_STG_BASE:  reg_rdata = stg_base;
      IDX_STG_LEN:   reg_rdata = {{PAD_W{1'b0}}, stg_len};
      IDX_LIVE_BASE: reg_rdata = live_base;
      default:       reg_rdata = {live_len, {(PAD_W-1){1'b0}}, load_q};
    endcase
  end

  AST_ZERO_LEN_PASS: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (live_len == '0) |-> (mem_addr == cpu_addr)); // R8

  AST_CORE_RST_LOAD: assert property (@(posedge clk) disable iff (!chip_rst_n)
    !core_rst_n |=> (live_base == $past(stg_base))); // R5

endmodule

// File: tb/boot_remap_tb_top.sv
module boot_remap_tb_top;

  localparam logic [31:0] BOOT = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        chip_rst_n = 1'b0;
  logic        core_rst_n = 1'b1;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic [31:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_remap dut_i (
    .clk(clk), .chip_rst_n(chip_rst_n), .core_rst_n(core_rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_addr(cpu_addr), .mem_addr(mem_addr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic xl(input logic [31:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1;
    d = mem_addr;
  endtask

  task automatic do_load();
    wr(2'd3, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 staging base", v, BOOT);
    rd(2'd1, v); chk("R1 staging len", v, 32'd63);
    rd(2'd2, v); chk("R1 live base", v, BOOT);
    rd(2'd3, v); chk("R1 ctrl", v, 32'h3F00_0000);
    xl(32'h100, v); chk("R9 default window", v, 32'hFFFF_0100);
  endtask

  task automatic t_stage_write();
    logic [31:0] v;
    wr(2'd0, 32'h2000_0000);
    wr(2'd1, 32'hABCD_0110);
    rd(2'd0, v); chk("R2 staging base", v, 32'h2000_0000);
    rd(2'd1, v); chk("R2 staging len low byte", v, 32'h10);
    rd(2'd2, v); chk("R3 live base held", v, BOOT);
    rd(2'd3, v); chk("R3 live len held", v, 32'h3F00_0000);
    xl(32'h100, v); chk("R3 translation held", v, 32'hFFFF_0100);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R4 load bit set", v, 32'h3F00_0001);
    rd(2'd2, v); chk("R4 live not yet copied", v, BOOT);
    @(negedge clk);
    rd(2'd3, v); chk("R4 R7 load cleared, live len", v, 32'h1000_0000);
    rd(2'd2, v); chk("R7 live base", v, 32'h2000_0000);
    xl(32'h21FC, v); chk("R9 last word in window", v, 32'h2000_21FC);
    xl(32'h2200, v); chk("R9 first address past window", v, 32'h2200);
    wr(2'd0, 32'h5000_0000);
    wr(2'd3, 32'h0);
    @(negedge clk);
    rd(2'd2, v); chk("R4 write of 0 has no effect", v, 32'h2000_0000);
    wr(2'd0, 32'h2000_0000);
  endtask

  task automatic t_ro_ignore();
    logic [31:0] v;
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'hFF00_0000);
    @(negedge clk);
    rd(2'd2, v); chk("R6 live base write ignored", v, 32'h2000_0000);
    rd(2'd3, v); chk("R6 live len write ignored", v, 32'h1000_0000);
  endtask

  task automatic t_core_reset();
    logic [31:0] v;
    wr(2'd0, 32'h3000_0000);
    wr(2'd1, 32'h0);
    @(negedge clk);
    core_rst_n = 1'b0;
    @(negedge clk);
    core_rst_n = 1'b1;
    rd(2'd2, v); chk("R5 core reset copies base", v, 32'h3000_0000);
    rd(2'd3, v); chk("R5 core reset copies len", v, 32'h0);
    rd(2'd0, v); chk("R5 staging survives core reset", v, 32'h3000_0000);
    xl(32'h40, v); chk("R8 zero length passes", v, 32'h40);
    xl(32'h0, v); chk("R8 address zero passes", v, 32'h0);
  endtask

  task automatic t_max();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FF00);
    wr(2'd1, 32'hFF);
    do_load();
    xl(32'h1_FFFF, v); chk("R10 top of 128KB window", v, 32'h0001_FEFF);
    xl(32'h2_0000, v); chk("R10 past 128KB window", v, 32'h2_0000);
    xl(32'h200, v); chk("R9 sum wraps modulo 2^32", v, 32'h100);
  endtask

  task automatic t_chip_reset();
    logic [31:0] v;
    @(negedge clk);
    chip_rst_n = 1'b0;
    @(negedge clk);
    chip_rst_n = 1'b1;
    rd(2'd0, v); chk("R1 chip reset restores staging base", v, BOOT);
    rd(2'd1, v); chk("R1 chip reset restores staging len", v, 32'd63);
    rd(2'd3, v); chk("R1 chip reset restores live len", v, 32'h3F00_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chip_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_write();
    t_load();
    t_ro_ignore();
    t_core_reset();
    t_max();
    t_chip_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule